// File: doc/BRIEF.md
# Line-Windowed Correction-Pulse Lock Detector

This block decides whether a video-reference phase-locked loop is in lock by counting how often its phase detector has to correct the oscillator. Each up or down correction strobe adds to a saturating counter. The counter is evaluated over an observation window. The window is measured in horizontal line-sync periods, not in clock cycles. When the window closes, the count is compared with an 8-bit threshold. The lock flag is raised if the count is no larger than the threshold and dropped otherwise. The window that follows opens on the same sync edge, so the decisions come back to back.

The window length comes from a 5-bit selector. A selector value `s` gives `floor(s/2)+1` line periods. The usual setting of 16 gives a nine-line window, and a setting of 31 gives the longest window of sixteen lines. The selector is sampled only at a window boundary. After reset the block waits in the ARM state for the first line sync, which opens the first window. It then moves through FIRST, the first window, during which the flag is forced low. It settles in RUN, where every closing sync produces a fresh verdict. The transitions are ARM→FIRST on the first line sync, FIRST→RUN on the first closing sync, and RUN→RUN on every later closing sync.

Top module: `lockdet_top`

## Requirements
- R1: After reset `lock_o` is 0, and it stays 0 until the first complete window has been evaluated.
- R2: Before the first `hsync_i` pulse after reset, correction strobes are ignored. That first pulse opens the first window.
- R3: Each cycle with `up_i` or `dn_i` high adds one to the window count. A cycle with both high adds two.
- R4: A window opened while `win_sel_i` = s lasts exactly s/2+1 `hsync_i` pulses, rounded down. The default selector 16 gives nine lines.
- R5: In the cycle after the closing `hsync_i`, `lock_o` is 1 if the window count is less than or equal to `thr_i`, read as 8-bit unsigned. Otherwise it is 0.
- R6: `lock_o` changes only in the cycle following a closing `hsync_i`. It holds through every other line sync and every other cycle.
- R7: A strobe that arrives in the same cycle as the closing `hsync_i` is counted in the next window.
- R8: The window count is 9 bits wide and saturates at 511 instead of wrapping. A heavily disturbed window therefore always reports no lock, whatever the threshold.
- R9: A change of `win_sel_i` in the middle of a window does not alter that window's length. The new value applies from the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Single-cycle upward correction strobe |
| dn_i | input | 1 | Single-cycle downward correction strobe |
| hsync_i | input | 1 | Single-cycle line-sync strobe |
| win_sel_i | input | 5 | Window-length selector, lines = sel/2+1 |
| thr_i | input | 8 | Largest count still judged as locked |
| lock_o | output | 1 | 1 = locked, 0 = no lock |

## Verification
The assertions assume that every strobe is a one-cycle pulse synchronous to `clk_i`. They also assume that line syncs are separated by at least one quiet cycle, so that a sync is never held high across two edges. The bench drives each line as one sync cycle followed by a fixed run of quiet cycles. It never holds a strobe for longer than one cycle per event. In every window it scrambles `win_sel_i` to a different value between the boundaries, so that R9 is exercised while the boundary value stays well defined.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

    // Controller states of the lock detector
    typedef enum logic [1:0] {
        ST_ARM   = 2'd0,   // waiting for first line sync
        ST_FIRST = 2'd1,   // first window, verdict forced to no-lock
        ST_RUN   = 2'd2    // steady windowed evaluation
    } lock_state_e;

endpackage

// File: rtl/lockdet_line_timer.sv
module lockdet_line_timer #(
    parameter int WIN_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hsync_i,
    input  logic             open_i,
    input  logic             active_i,
    input  logic [WIN_W-1:0] win_sel_i,
    output logic             close_o
);

    // index of the last line in the window (lines - 1)
    logic [WIN_W-1:0] term_q;
    logic [WIN_W-1:0] line_q;
    logic [WIN_W-1:0] term_next;

    assign term_next = win_sel_i >> 1;
    assign close_o   = active_i && hsync_i && (line_q == term_q);

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            term_q <= '0;
            line_q <= '0;
        end else if (open_i || close_o) begin
            term_q <= term_next;
            line_q <= '0;
        end else if (active_i && hsync_i) begin
            line_q <= line_q + 1'b1;
        end
    end

endmodule

// File: rtl/lockdet_pulse_acc.sv
module lockdet_pulse_acc #(
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             restart_i,
    input  logic             enable_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [1:0]       inc;
    logic [CNT_W:0]   sum;
    logic [CNT_W-1:0] sat;
    logic [CNT_W-1:0] cnt_q;

    assign inc = {1'b0, up_i} + {1'b0, dn_i};
    assign sum = {1'b0, cnt_q} + (CNT_W+1)'(inc);
    assign sat = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= CNT_W'(inc);
        end else if (enable_i) begin
            cnt_q <= sat;
        end else begin
            cnt_q <= '0;
        end
    end

    assign count_o = cnt_q;

endmodule

// File: rtl/lockdet_ctrl.sv
module lockdet_ctrl
    import lockdet_pkg::*;
#(
    parameter int THR_W = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             hsync_i,
    input  logic             close_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [THR_W-1:0] thr_i,
    output lock_state_e      state_o,
    output logic             open_o,
    output logic             active_o,
    output logic             restart_o,
    output logic             lock_o
);

    lock_state_e state_q, state_d;
    logic        lock_q;
    logic        verdict;

    assign verdict = (count_i <= CNT_W'(thr_i));

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_ARM;
        else         state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:   if (hsync_i) state_d = ST_FIRST;
            ST_FIRST: if (close_i) state_d = ST_RUN;
            ST_RUN:   state_d = ST_RUN;
            default:  state_d = ST_ARM;
        endcase
    end

    // registered verdict output
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lock_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ARM:           lock_q <= 1'b0;
                ST_FIRST, ST_RUN: if (close_i) lock_q <= verdict;
                default:          lock_q <= 1'b0;
            endcase
        end
    end

    assign open_o    = (state_q == ST_ARM) && hsync_i;
    assign active_o  = (state_q != ST_ARM);
    assign restart_o = open_o || close_i;
    assign state_o   = state_q;
    assign lock_o    = lock_q;

endmodule

// File: rtl/lockdet_top.sv
module lockdet_top
    import lockdet_pkg::*;
#(
    parameter int WIN_W = 5,
    parameter int THR_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             up_i,
    input  logic             dn_i,
    input  logic             hsync_i,
    input  logic [WIN_W-1:0] win_sel_i,
    input  logic [THR_W-1:0] thr_i,
    output logic             lock_o
);

    localparam int CNT_W = THR_W + 1;

    lock_state_e      state_w;
    logic             open_w;
    logic             active_w;
    logic             restart_w;
    logic             close_w;
    logic [CNT_W-1:0] count_w;

    lockdet_line_timer #(.WIN_W(WIN_W)) timer_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hsync_i   (hsync_i),
        .open_i    (open_w),
        .active_i  (active_w),
        .win_sel_i (win_sel_i),
        .close_o   (close_w)
    );

    lockdet_pulse_acc #(.CNT_W(CNT_W)) acc_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .up_i      (up_i),
        .dn_i      (dn_i),
        .restart_i (restart_w),
        .enable_i  (active_w),
        .count_o   (count_w)
    );

    lockdet_ctrl #(.THR_W(THR_W), .CNT_W(CNT_W)) ctrl_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hsync_i   (hsync_i),
        .close_i   (close_w),
        .count_i   (count_w),
        .thr_i     (thr_i),
        .state_o   (state_w),
        .open_o    (open_w),
        .active_o  (active_w),
        .restart_o (restart_w),
        .lock_o    (lock_o)
    );

endmodule

// File: rtl/lockdet_chk.sv
module lockdet_chk
    import lockdet_pkg::*;
#(
    parameter int WIN_W = 5,
    parameter int THR_W = 8,
    parameter int CNT_W = THR_W + 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             up_i,
    input logic             dn_i,
    input logic             hsync_i,
    input logic [WIN_W-1:0] win_sel_i,
    input logic [THR_W-1:0] thr_i,
    input logic             lock_o,
    input lock_state_e      state_w,
    input logic             open_w,
    input logic             active_w,
    input logic             restart_w,
    input logic             close_w,
    input logic [CNT_W-1:0] count_w
);

    localparam logic [CNT_W-1:0] CMAX = '1;

    logic           seen_close;
    logic           win_live;
    logic [WIN_W:0] lines_seen;
    logic [WIN_W:0] exp_lines;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_close <= 1'b0;
            win_live   <= 1'b0;
            lines_seen <= '0;
            exp_lines  <= '0;
        end else begin
            if (close_w) seen_close <= 1'b1;
            if (open_w || close_w) begin
                win_live   <= 1'b1;
                lines_seen <= '0;
                exp_lines  <= (WIN_W+1)'(win_sel_i / 2) + 1'b1;
            end else if (hsync_i) begin
                lines_seen <= lines_seen + 1'b1;
            end
        end
    end

    // R1
    nolock_before_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !seen_close |-> !lock_o);

    // R2
    arm_ignores_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_w == ST_ARM && !hsync_i) |=> count_w == '0);

    // R3
    double_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_w && !restart_w && up_i && dn_i && count_w < CMAX - 1'b1)
        |=> count_w == $past(count_w) + 2'd2);

    // R4
    window_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_live && close_w) |-> (lines_seen + 1'b1 == exp_lines));

    // R4
    no_early_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (win_live && hsync_i && !close_w) |-> (lines_seen + 1'b1 < exp_lines));

    // R5
    unlock_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (close_w && count_w > CNT_W'(thr_i)) |=> !lock_o);

    // R5
    lock_verdict_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (close_w && count_w <= CNT_W'(thr_i)) |=> lock_o);

    // R6
    status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !hsync_i |=> $stable(lock_o));

    // R7
    edge_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (close_w && up_i && !dn_i) |=> count_w == CNT_W'(1));

    // R8
    no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_w && !restart_w) |=> count_w >= $past(count_w));

endmodule

bind lockdet_top lockdet_chk #(.WIN_W(WIN_W), .THR_W(THR_W)) chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .up_i      (up_i),
    .dn_i      (dn_i),
    .hsync_i   (hsync_i),
    .win_sel_i (win_sel_i),
    .thr_i     (thr_i),
    .lock_o    (lock_o),
    .state_w   (state_w),
    .open_w    (open_w),
    .active_w  (active_w),
    .restart_w (restart_w),
    .close_w   (close_w),
    .count_w   (count_w)
);

// File: tb/lockdet_top_tb.sv
module lockdet_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk_i = 1'b0;
    logic       rst_ni;
    logic       up_i, dn_i, hsync_i;
    logic [4:0] win_sel_i;
    logic [7:0] thr_i;
    logic       lock_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int   line_len = 8;
    int   carry    = 0;
    bit   prev_lock = 0;
    logic [4:0] cur_sel = 5'd16;

    always #(CLK_PERIOD/2) clk_i = ~clk_i;

    lockdet_top dut_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .up_i      (up_i),
        .dn_i      (dn_i),
        .hsync_i   (hsync_i),
        .win_sel_i (win_sel_i),
        .thr_i     (thr_i),
        .lock_o    (lock_o)
    );

    task automatic check(input bit got, input bit exp, input string tag);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: lock_o=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    // open the first window with a line sync using cur_sel
    task automatic open_first();
        @(negedge clk_i);
        hsync_i = 1'b1; up_i = 1'b0; dn_i = 1'b0; win_sel_i = cur_sel;
        @(negedge clk_i);
        hsync_i = 1'b0;
    endtask

    // run one full window with cur_sel; window already opened
    task automatic run_window(input int nup, input int ndn, input logic [4:0] next_sel,
                              input bit edge_up, input string tag);
        int lines = int'(cur_sel) / 2 + 1;
        int tot   = carry + nup + ndn;
        int sat   = (tot > 511) ? 511 : tot;
        bit exp   = (sat <= int'(thr_i));
        int ru = nup;
        int rd = ndn;
        logic [4:0] noise = ~cur_sel;
        for (int l = 0; l < lines; l++) begin
            for (int c = 0; c < line_len - 1; c++) begin
                @(negedge clk_i);
                if (c == 0 && l > 0) check(lock_o, prev_lock, {tag, " R6 hold inside window (R4 length)"});
                hsync_i   = 1'b0;
                up_i      = (ru > 0);
                dn_i      = (rd > 0);
                win_sel_i = noise;           // R9: mid-window change
                if (ru > 0) ru--;
                if (rd > 0) rd--;
            end
            @(negedge clk_i);
            hsync_i = 1'b1;
            dn_i    = 1'b0;
            if (l == lines - 1) begin
                up_i      = edge_up;
                win_sel_i = next_sel;
            end else begin
                up_i      = 1'b0;
                win_sel_i = noise;
            end
        end
        @(negedge clk_i);
        check(lock_o, exp, {tag, " R5 verdict"});
        hsync_i = 1'b0; up_i = 1'b0; dn_i = 1'b0;
        prev_lock = exp;
        carry   = edge_up ? 1 : 0;
        cur_sel = next_sel;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [4:0] sweep [8] = '{5'd0, 5'd1, 5'd2, 5'd5, 5'd17, 5'd30, 5'd31, 5'd16};
        rst_ni = 1'b0; up_i = 1'b0; dn_i = 1'b0; hsync_i = 1'b0;
        win_sel_i = 5'd16; thr_i = 8'd0;
        repeat (3) @(negedge clk_i);
        check(lock_o, 1'b0, "R1 reset value");
        rst_ni = 1'b1;

        // R2: strobes before the first line sync are discarded
        for (int i = 0; i < 20; i++) begin
            @(negedge clk_i);
            up_i = 1'b1; dn_i = 1'b1;
        end
        @(negedge clk_i);
        up_i = 1'b0; dn_i = 1'b0;
        check(lock_o, 1'b0, "R1 still no lock while armed");

        open_first();
        // first window: nine lines (R4 default), thr 0, no pulses -> lock (R2, R1)
        run_window(0, 0, 5'd16, 1'b0, "R2 first window");
        // one pulse over thr 0 -> unlock, proves nine-line length
        run_window(1, 0, 5'd16, 1'b0, "R4 default nine lines");

        // R4 sweep of window lengths, alternating verdicts, R3 overlap of up/dn
        thr_i = 8'd3;
        foreach (sweep[i]) begin
            if (prev_lock) run_window(2, 2, sweep[i], 1'b0, "R3 R4 sweep over");
            else           run_window(2, 1, sweep[i], 1'b0, "R3 R4 sweep at thr");
        end
        // cur_sel now 16; ensure lock state known
        // R7: pulse on closing sync counts into next window
        thr_i = 8'd2;
        if (!prev_lock) run_window(0, 0, 5'd16, 1'b0, "R5 relock");
        run_window(1, 1, 5'd4, 1'b1, "R7 edge pulse excluded");
        run_window(1, 1, 5'd4, 1'b0, "R7 edge pulse carried");
        run_window(0, 0, 5'd31, 1'b0, "R5 zero pulses");

        // R8 and threshold extremes on long windows
        line_len = 40;
        thr_i = 8'd255;
        run_window(128, 127, 5'd31, 1'b0, "R5 count 255 at thr 255");
        run_window(600, 600, 5'd31, 1'b0, "R8 saturation above 255");
        run_window(100, 100, 5'd31, 1'b0, "R8 recovery after saturation");
        run_window(128, 128, 5'd31, 1'b0, "R5 count 256 at thr 255");
        thr_i = 8'd0;
        run_window(0, 0, 5'd31, 1'b0, "R5 thr 0 empty");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule